// File: doc/BRIEF.md
# Compatibility-Mode Register Move Filter

This block sits on the write path of a 24-bit processor's program-control register file, between the move source bus and the destination registers. Every move arrives as one transfer carrying a source select, a destination select and a 24-bit word. The block sends the word on with a data value and one enable per byte lane, and the register file writes only the enabled lanes. A compatibility mode bit controls what happens to the top byte. When the bit is clear, every move writes all 24 bits unchanged. When it is set, the top byte may be forced to zero or left untouched in the destination, depending on which registers the move reads and writes.

A write to the mode bit does not take effect at once. The filter uses a copy of the bit that has passed through a short register chain. Each move therefore sees the mode value from three clock edges earlier, which matches the pipeline latency of the control unit.

Moves use a valid/ready handshake. The filter adds no storage, so valid passes from the move side to the write side in the same cycle, and ready passes back the same way. A move is accepted in a cycle where both `mv_valid_i` and `wr_ready_i` are high. While a move is stalled, the sender must hold its select and data inputs steady. The effective mode can still advance during a stall, and the write data reflects the mode at the cycle of acceptance.

Top module: `rmm_move_filter`

## Requirements

Register select codes:

| Code | Register | Group |
|------|----------|-------|
| 0 | loop address | narrow |
| 1 | loop count | narrow |
| 2 | stack pointer | narrow |
| 3 | stack low | narrow |
| 4 | stack high | narrow |
| 5 | extension pointer | narrow |
| 6 | stack size | narrow |
| 7 | vector base | narrow |
| 8 | stack counter | narrow |
| 9 | status register | wide-control |
| 10 | operating mode register | wide-control |
| 11 to 15 | any other register | plain |

Write lanes: bit i of `wr_lane_en_o` enables data bits [8i+7:8i], so bit 2 is the top byte. In the requirements below, "mode" means the effective (delayed) mode.

- R1: After reset, the effective mode is 0, and moves pass all 24 bits with all three lanes enabled, whatever `mode_bit_i` was during reset.
- R2: `wr_valid_o` equals `mv_valid_i`, and `mv_ready_o` equals `wr_ready_i`, in the same cycle.
- R3: With mode 0, `wr_data_o` equals `src_data_i` and `wr_lane_en_o` is 3'b111, for every source and destination code.
- R4: With mode 1 and a destination code from 0 to 8, bits [23:16] of `wr_data_o` are 0, bits [15:0] equal the source data, and all three lanes are enabled.
- R5: With mode 1, a source code of 9 or 10 and a plain destination (code 11 to 15), bits [23:16] of `wr_data_o` are 0 and all three lanes are enabled.
- R6: With mode 1 and a destination code of 9 or 10, lane 2 is disabled, lanes 0 and 1 are enabled, and bits [23:16] of `wr_data_o` are 0. This rule applies whatever the source is, including a source code of 9 or 10.
- R7: With mode 1, a plain destination and a source that is not 9 or 10, all 24 bits pass unchanged and all three lanes are enabled.
- R8: A value on `mode_bit_i` sampled at a rising clock edge becomes the effective mode after the third rising edge, counting that edge as the first. Moves in the cycles before that point use the previous value.
- R9: Bits [15:0] of `wr_data_o` always equal bits [15:0] of `src_data_i`, and lanes 0 and 1 are always enabled.

## Ports

| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_bit_i | input | 1 | Architectural compatibility mode bit |
| mv_valid_i | input | 1 | Move transfer present |
| mv_ready_o | output | 1 | Move transfer can be taken |
| src_sel_i | input | 4 | Source register code |
| dst_sel_i | input | 4 | Destination register code |
| src_data_i | input | 24 | Word read from the source register |
| wr_valid_o | output | 1 | Register write present |
| wr_ready_i | input | 1 | Register file takes the write |
| wr_data_o | output | 24 | Data to write |
| wr_lane_en_o | output | 3 | Enable for each byte lane |

## Verification

The assertions assume that the select and data inputs are never X while reset is released. They also assume the checker's notion of the effective mode, the delayed copy of the bit, is the one the filter decides with. The assertions do not depend on the handshake being well behaved, so valid and ready are toggled at random and independently of each other. The stimulus draws select codes only from the 4-bit range and data as full random words. It changes the mode bit rarely enough that every delay window settles, and it also includes back-to-back flips.

// File: rtl/rmm_pkg.sv
package rmm_pkg;

  // Register select codes (4-bit). Codes 0..8 form a contiguous group.
  localparam logic [3:0] RID_LOOP_ADDR  = 4'd0;
  localparam logic [3:0] RID_LOOP_CNT   = 4'd1;
  localparam logic [3:0] RID_STK_PTR    = 4'd2;
  localparam logic [3:0] RID_STK_LO     = 4'd3;
  localparam logic [3:0] RID_STK_HI     = 4'd4;
  localparam logic [3:0] RID_EXT_PTR    = 4'd5;
  localparam logic [3:0] RID_STK_SIZE   = 4'd6;
  localparam logic [3:0] RID_VEC_BASE   = 4'd7;
  localparam logic [3:0] RID_STK_CNT    = 4'd8;
  localparam logic [3:0] RID_STATUS     = 4'd9;
  localparam logic [3:0] RID_OPMODE     = 4'd10;

  // Group of a register as seen by the masking policy.
  typedef enum logic [1:0] {
    CLS_PLAIN   = 2'd0,  // full width, never masked
    CLS_NARROW  = 2'd1,  // top byte forced to zero in compatibility mode
    CLS_WIDECTL = 2'd2   // status / operating mode: top byte protected
  } reg_class_e;

endpackage

// File: rtl/rmm_mode_delay.sv
module rmm_mode_delay #(
  parameter int unsigned LAT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [LAT-1:0] chain;

  generate
    if (LAT == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[LAT-2:0], d};
      end
    end
  endgenerate

  assign q = chain[LAT-1];

endmodule

// File: rtl/rmm_classify.sv
module rmm_classify #(
  parameter int unsigned SEL_W = 4
) (
  input  logic [SEL_W-1:0]        sel,
  output rmm_pkg::reg_class_e     cls
);
  import rmm_pkg::*;

  always_comb begin
    if (sel <= SEL_W'(RID_STK_CNT))
      cls = CLS_NARROW;
    else if (sel == SEL_W'(RID_STATUS) || sel == SEL_W'(RID_OPMODE))
      cls = CLS_WIDECTL;
    else
      cls = CLS_PLAIN;
  end

endmodule

// File: rtl/rmm_lane_policy.sv
module rmm_lane_policy #(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned LANES = DATA_W / LANE_W
) (
  input  logic                 mode,
  input  rmm_pkg::reg_class_e  src_cls,
  input  rmm_pkg::reg_class_e  dst_cls,
  input  logic [DATA_W-1:0]    data_in,
  output logic [DATA_W-1:0]    data_out,
  output logic [LANES-1:0]     lane_en
);
  import rmm_pkg::*;

  localparam int unsigned TOP = LANES - 1;

  logic keep_top;   // destination keeps its old top byte
  logic zero_top;   // top byte written as zero

  always_comb begin
    keep_top = mode && (dst_cls == CLS_WIDECTL);
    // Protection of the destination outranks the clearing rules.
    zero_top = mode && (keep_top || dst_cls == CLS_NARROW || src_cls == CLS_WIDECTL);
  end

  always_comb begin
    data_out = data_in;
    lane_en  = '1;
    if (zero_top) data_out[DATA_W-1 -: LANE_W] = '0;
    if (keep_top) lane_en[TOP] = 1'b0;
  end

endmodule

// File: rtl/rmm_move_filter.sv
module rmm_move_filter #(
  parameter int unsigned DATA_W   = 24,
  parameter int unsigned LANE_W   = 8,
  parameter int unsigned SEL_W    = 4,
  parameter int unsigned MODE_LAT = 3,
  localparam int unsigned LANES   = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_bit_i,
  input  logic              mv_valid_i,
  output logic              mv_ready_o,
  input  logic [SEL_W-1:0]  src_sel_i,
  input  logic [SEL_W-1:0]  dst_sel_i,
  input  logic [DATA_W-1:0] src_data_i,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [LANES-1:0]  wr_lane_en_o
);
  import rmm_pkg::*;

  logic       mode_eff;
  reg_class_e src_cls;
  reg_class_e dst_cls;

  rmm_mode_delay #(.LAT(MODE_LAT)) u_dly (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (mode_bit_i),
    .q    (mode_eff)
  );

  rmm_classify #(.SEL_W(SEL_W)) u_src_cls (
    .sel(src_sel_i),
    .cls(src_cls)
  );

  rmm_classify #(.SEL_W(SEL_W)) u_dst_cls (
    .sel(dst_sel_i),
    .cls(dst_cls)
  );

  rmm_lane_policy #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_pol (
    .mode    (mode_eff),
    .src_cls (src_cls),
    .dst_cls (dst_cls),
    .data_in (src_data_i),
    .data_out(wr_data_o),
    .lane_en (wr_lane_en_o)
  );

  // No storage at the edge: handshake passes straight through.
  assign wr_valid_o = mv_valid_i;
  assign mv_ready_o = wr_ready_i;

endmodule

// File: rtl/rmm_checker.sv
module rmm_checker #(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned LANE_W = 8,
  parameter int unsigned SEL_W  = 4,
  localparam int unsigned LANES = DATA_W / LANE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_eff,
  input logic              mv_valid_i,
  input logic              mv_ready_o,
  input logic [SEL_W-1:0]  src_sel_i,
  input logic [SEL_W-1:0]  dst_sel_i,
  input logic [DATA_W-1:0] src_data_i,
  input logic              wr_valid_o,
  input logic              wr_ready_i,
  input logic [DATA_W-1:0] wr_data_o,
  input logic [LANES-1:0]  wr_lane_en_o
);
  import rmm_pkg::*;

  localparam int unsigned LOW_W = DATA_W - LANE_W;

  logic dst_narrow, dst_wide, src_wide, dst_plain;
  assign dst_narrow = dst_sel_i <= SEL_W'(RID_STK_CNT);
  assign dst_wide   = dst_sel_i == SEL_W'(RID_STATUS) || dst_sel_i == SEL_W'(RID_OPMODE);
  assign src_wide   = src_sel_i == SEL_W'(RID_STATUS) || src_sel_i == SEL_W'(RID_OPMODE);
  assign dst_plain  = !dst_narrow && !dst_wide;

  assert_handshake_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o == mv_valid_i) && (mv_ready_o == wr_ready_i));

  assert_mode_off_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_eff |-> (wr_data_o == src_data_i) && (&wr_lane_en_o));

  assert_narrow_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_eff && dst_narrow) |->
      (wr_data_o[DATA_W-1 -: LANE_W] == '0) && (&wr_lane_en_o));

  assert_src_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_eff && src_wide && dst_plain) |->
      (wr_data_o[DATA_W-1 -: LANE_W] == '0) && (&wr_lane_en_o));

  assert_keep_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_eff && dst_wide) |-> !wr_lane_en_o[LANES-1]);

  assert_plain_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_eff && !src_wide && dst_plain) |-> (wr_data_o == src_data_i));

  assert_low_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data_o[LOW_W-1:0] == src_data_i[LOW_W-1:0]) && (&wr_lane_en_o[LANES-2:0]));

endmodule

bind rmm_move_filter rmm_checker #(
  .DATA_W(DATA_W), .LANE_W(LANE_W), .SEL_W(SEL_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_eff    (mode_eff),
  .mv_valid_i  (mv_valid_i),
  .mv_ready_o  (mv_ready_o),
  .src_sel_i   (src_sel_i),
  .dst_sel_i   (dst_sel_i),
  .src_data_i  (src_data_i),
  .wr_valid_o  (wr_valid_o),
  .wr_ready_i  (wr_ready_i),
  .wr_data_o   (wr_data_o),
  .wr_lane_en_o(wr_lane_en_o)
);

// File: tb/tb_rmm_move_filter.sv
module tb_rmm_move_filter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_bit_i = 1'b0;
  logic        mv_valid_i = 1'b0;
  logic        mv_ready_o;
  logic [3:0]  src_sel_i = '0;
  logic [3:0]  dst_sel_i = '0;
  logic [23:0] src_data_i = '0;
  logic        wr_valid_o;
  logic        wr_ready_i = 1'b0;
  logic [23:0] wr_data_o;
  logic [2:0]  wr_lane_en_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  logic [2:0] pipe = '0;  // bench model of the mode delay

  always #5 clk = ~clk;

  rmm_move_filter dut (
    .clk(clk), .rst_n(rst_n), .mode_bit_i(mode_bit_i),
    .mv_valid_i(mv_valid_i), .mv_ready_o(mv_ready_o),
    .src_sel_i(src_sel_i), .dst_sel_i(dst_sel_i), .src_data_i(src_data_i),
    .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i),
    .wr_data_o(wr_data_o), .wr_lane_en_o(wr_lane_en_o)
  );

  // Expected {data, lanes} from the requirements.
  function automatic logic [26:0] expect_f(logic [3:0] s, logic [3:0] d,
                                           logic [23:0] w, logic m);
    logic dn = (d <= 4'd8);
    logic dw = (d == 4'd9) || (d == 4'd10);
    logic sw = (s == 4'd9) || (s == 4'd10);
    logic [23:0] o = w;
    logic [2:0]  l = 3'b111;
    if (m) begin
      if (dw) begin o[23:16] = 8'h00; l = 3'b011; end       // R6
      else if (dn || sw) o[23:16] = 8'h00;                  // R4, R5
    end
    return {o, l};
  endfunction

  task automatic step();
    @(posedge clk);
    if (!rst_n) pipe = '0;
    else        pipe = {pipe[1:0], mode_bit_i};
    @(negedge clk);
  endtask

  task automatic chk(string req);
    logic [26:0] e = expect_f(src_sel_i, dst_sel_i, src_data_i, pipe[2]);
    n_cmp++;
    if ({wr_data_o, wr_lane_en_o} !== e || wr_valid_o !== mv_valid_i ||
        mv_ready_o !== wr_ready_i) begin
      n_bad++;
      $display("FAIL %s: actual data=%h lanes=%b v=%b r=%b expected data=%h lanes=%b v=%b r=%b",
               req, wr_data_o, wr_lane_en_o, wr_valid_o, mv_ready_o,
               e[26:3], e[2:0], mv_valid_i, wr_ready_i);
    end
  endtask

  task automatic drive(logic [3:0] s, logic [3:0] d, logic [23:0] w);
    src_sel_i = s; dst_sel_i = d; src_data_i = w;
    mv_valid_i = 1'b1; wr_ready_i = 1'b1;
    #1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R2 watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'h5eed_0042));
    mode_bit_i = 1'b1;               // held high during reset: must not leak (R1)
    repeat (3) step();
    rst_n = 1'b1;
    drive(4'd1, 4'd1, 24'hABCDEF); chk("R1 reset state");
    step(); drive(4'd9, 4'd0, 24'hFF1234); chk("R1 one edge after reset");

    // Let mode 1 settle, then the directed corners.
    repeat (3) step();
    drive(4'd12, 4'd0, 24'hFFFFFF); chk("R4 narrow destination cleared");
    drive(4'd9, 4'd13, 24'hA5A5A5); chk("R5 status source cleared");
    drive(4'd10, 4'd9, 24'hC3C3C3); chk("R6 preserve wins over source clear");
    drive(4'd3, 4'd10, 24'h7F0001); chk("R6 operating mode destination");
    drive(4'd14, 4'd15, 24'hDEADBE); chk("R7 plain move unchanged");
    drive(4'd11, 4'd8, 24'h80FFFF); chk("R9 low bits kept");

    // Delay window (R8): flip to 0 and watch three edges.
    mode_bit_i = 1'b0;
    drive(4'd12, 4'd1, 24'hFF00AA); chk("R8 edge 0 old mode");
    step(); #1; chk("R8 edge 1 old mode");
    step(); #1; chk("R8 edge 2 old mode");
    step(); #1; chk("R8 edge 3 new mode");
    drive(4'd9, 4'd10, 24'hFEDCBA); chk("R3 mode off full width");

    // Back-to-back flips inside the window.
    mode_bit_i = 1'b1; step(); mode_bit_i = 1'b0; step();
    mode_bit_i = 1'b1;
    for (int i = 0; i < 6; i++) begin
      drive(4'd2, 4'd2, 24'hF0F0F0); chk("R8 overlapping flips");
      step();
    end

    // Constrained random traffic.
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 19) == 0) mode_bit_i = ~mode_bit_i;
      src_sel_i  = 4'($urandom_range(0, 15));
      dst_sel_i  = 4'($urandom_range(0, 15));
      src_data_i = 24'($urandom);
      mv_valid_i = 1'($urandom);
      wr_ready_i = 1'($urandom);
      #1;
      chk(pipe[2] ? "R4 R5 R6 R7 R9 random" : "R2 R3 random");
      step();
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule